// File: doc/BRIEF.md
# Converter Control and Threshold Sense Sequencer

This block is the digital controller that wraps a successive-approximation converter core. Software reaches it through a small byte-wide register window: a command/status register, a configuration register, a two-byte result and an 8-bit threshold. An operation is launched either by a software start command or, when the external trigger is armed, by a rising edge on a trigger pin. The length of each operation is set in clock cycles by a two-bit time-select field. The busy state is visible both as a status bit and as a pin.

There are two operating modes. In convert mode the sampled word is latched into the result registers when the operation ends, and a sticky completion flag is set. In sense mode the upper eight bits of the sampled word are compared with the threshold register. The completion flag is set only when the selected condition holds: strictly below the threshold, or strictly above it. The result registers are left as they were. The completion flag, gated by an interrupt-enable bit, drives the interrupt pin.

The sampled word is a plain level input with no handshake. The block takes it in the clock edge on which an operation completes. It has no valid/ready pair and applies no back-pressure. The upstream source must simply present the value it wants measured by that edge.

Top module: `adc_seq_top`

## Requirements
- R1: In convert mode (configuration bit 2 = 0), time-select (configuration bits 6:5) values 0,1,2,3 keep the operation busy for exactly 33, 48, 66 and 90 clock cycles.
- R2: In sense mode (configuration bit 2 = 1), the same time-select values give 18, 33, 51 and 75 busy cycles.
- R3: Command register (address 0) bit 2 and the busy pin are 1 from the cycle after a launch until the operation completes, and 0 at all other times, including after reset.
- R4: When a convert operation completes, address 2 reads the sample's bits 9:8 in its bits 1:0 (upper bits 0), address 3 reads the sample's bits 7:0, and the completion flag (address 0 bit 3) is set.
- R5: When a sense operation completes, the flag is set only when sample bits 9:2 are strictly below the threshold (address 4) with address 0 bit 1 = 0, or strictly above it with bit 1 = 1. The result registers keep their values.
- R6: Writing address 0 with bit 0 = 1 launches an operation when external trigger enable (configuration bit 1) is 0. Writing bit 0 = 0 launches nothing, and bit 0 always reads 0.
- R7: With external trigger enable = 1, a rising edge of ext_trig launches an operation, a trigger held high launches only once, and software start writes are ignored.
- R8: A launch request made while busy is ignored, and a time-select write during an operation does not change its length.
- R9: The completion flag is sticky. Writing address 0 with bit 3 = 0 clears it, and writing bit 3 = 1 leaves it unchanged. The irq pin equals the flag AND interrupt enable (configuration bit 3).
- R10: The configuration register (address 1) resets to 0x01 and holds written bits 6:0, with bit 7 reading 0. The other registers reset to 0.
- R11: While bus_rmw is 1, a read of address 0 returns 1 in bit 3 whatever the flag holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_rmw | input | 1 | Marks the current read as the read half of a read-modify-write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| sample_in | input | 10 | Digital word standing in for the sampled analog input |
| ext_trig | input | 1 | External launch trigger, synchronous to clk |
| busy | output | 1 | Operation in progress |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that ext_trig and every bus input are already synchronous to clk. They also assume that one write strobe carries one address for a whole cycle. The stimulus meets this by changing inputs only on the falling clock edge. sample_in is changed only while the block is idle, so the value measured is the one the bench predicts. bus_rmw is raised only around reads of the command register, so a write is never mistaken for the read half of a read-modify-write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned LONGEST_OP = 90;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CFG    = 3'd1,
    A_RES_HI = 3'd2,
    A_RES_LO = 3'd3,
    A_THR    = 3'd4
  } reg_addr_e;

  typedef enum logic {
    OP_CONVERT = 1'b0,
    OP_SENSE   = 1'b1
  } op_mode_e;

  typedef struct packed {
    logic [1:0] tsel;
    logic       clk_sel;
    logic       irq_en;
    op_mode_e   mode;
    logic       ext_en;
    logic       test;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{tsel: 2'b00, clk_sel: 1'b0, irq_en: 1'b0,
                                 mode: OP_CONVERT, ext_en: 1'b0, test: 1'b1};

  // command register bit positions
  localparam int unsigned B_START = 0;
  localparam int unsigned B_ABOVE = 1;
  localparam int unsigned B_BUSY  = 2;
  localparam int unsigned B_END   = 3;

  function automatic int unsigned op_length(input op_mode_e m, input logic [1:0] t);
    int unsigned n;
    if (m == OP_CONVERT) begin
      case (t)
        2'd0:    n = 33;
        2'd1:    n = 48;
        2'd2:    n = 66;
        default: n = 90;
      endcase
    end else begin
      case (t)
        2'd0:    n = 18;
        2'd1:    n = 33;
        2'd2:    n = 51;
        default: n = 75;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_start,
  input  logic       ext_en,
  input  logic       ext_trig,
  input  op_mode_e   mode,
  input  logic [1:0] tsel,
  output logic       busy,
  output logic       done
);

  logic             trig_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ext_edge;
  logic             launch;

  assign ext_edge = ext_trig & ~trig_q;
  assign launch   = ~busy_q & (ext_en ? ext_edge : sw_start);
  assign done     = busy_q & (cnt_q == '0);
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      trig_q <= ext_trig;
      if (launch) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(op_length(mode, tsel) - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  p_len_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CNT_W'(LONGEST_OP - 1)));

  p_done_idles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

  p_ext_masks_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && sw_start && !busy_q && !(ext_trig && !trig_q)) |=> !busy_q);

  p_run_undisturbed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_seq_eval.sv
module adc_seq_eval
  import adc_seq_pkg::*;
#(
  parameter int unsigned SMP_W  = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  op_mode_e          mode,
  input  logic              above_sel,
  input  logic [SMP_W-1:0]  sample,
  input  logic [DATA_W-1:0] thresh,
  output logic [SMP_W-1:0]  result,
  output logic              end_set
);

  logic [DATA_W-1:0] cmp_word;
  logic              hit;

  assign cmp_word = sample[SMP_W-1 -: DATA_W];
  assign hit      = above_sel ? (cmp_word > thresh) : (cmp_word < thresh);
  assign end_set  = done & ((mode == OP_CONVERT) | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          result <= '0;
    else if (done && mode == OP_CONVERT) result <= sample;
  end

  p_conv_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == OP_CONVERT) |=> (result == $past(sample)));

  p_sense_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == OP_SENSE) |=> $stable(result));

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SMP_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rmw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              end_set,
  input  logic [SMP_W-1:0]  result,
  output logic [1:0]        tsel,
  output op_mode_e          mode,
  output logic              ext_en,
  output logic              above_sel,
  output logic [DATA_W-1:0] thresh,
  output logic              sw_start,
  output logic              irq
);

  localparam int unsigned CFG_W = $bits(cfg_t);

  cfg_t              cfg_q;
  logic              above_q;
  logic              end_q;
  logic [DATA_W-1:0] thr_q;
  logic              wr_ctrl;
  logic              clr_end;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign clr_end  = wr_ctrl && !bus_wdata[B_END];
  assign sw_start = wr_ctrl && bus_wdata[B_START];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      above_q <= 1'b0;
      end_q   <= 1'b0;
      thr_q   <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CFG) cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
      if (bus_wr && bus_addr == A_THR) thr_q <= bus_wdata;
      if (wr_ctrl) above_q <= bus_wdata[B_ABOVE];
      if (end_set)      end_q <= 1'b1;
      else if (clr_end) end_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_ABOVE] = above_q;
        bus_rdata[B_BUSY]  = busy;
        bus_rdata[B_END]   = end_q | bus_rmw;
      end
      A_CFG:    bus_rdata[CFG_W-1:0] = cfg_q;
      A_RES_HI: bus_rdata = DATA_W'(result >> DATA_W);
      A_RES_LO: bus_rdata = result[DATA_W-1:0];
      A_THR:    bus_rdata = thr_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign tsel      = cfg_q.tsel;
  assign mode      = cfg_q.mode;
  assign ext_en    = cfg_q.ext_en;
  assign above_sel = above_q;
  assign thresh    = thr_q;
  assign irq       = end_q & cfg_q.irq_en;

  p_end_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !clr_end) |=> end_q);

  p_start_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> !bus_rdata[B_START]);

  p_rmw_end_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rmw && bus_addr == A_CTRL) |-> bus_rdata[B_END]);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SMP_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rmw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SMP_W-1:0]  sample_in,
  input  logic              ext_trig,
  output logic              busy,
  output logic              irq
);

  localparam int unsigned CNT_W = $clog2(LONGEST_OP);

  logic              done;
  logic              end_set;
  logic              sw_start;
  logic              ext_en;
  logic              above_sel;
  logic [1:0]        tsel;
  op_mode_e          mode;
  logic [DATA_W-1:0] thresh;
  logic [SMP_W-1:0]  result;

  adc_seq_regs #(.DATA_W(DATA_W), .SMP_W(SMP_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rmw   (bus_rmw),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .end_set   (end_set),
    .result    (result),
    .tsel      (tsel),
    .mode      (mode),
    .ext_en    (ext_en),
    .above_sel (above_sel),
    .thresh    (thresh),
    .sw_start  (sw_start),
    .irq       (irq)
  );

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_start (sw_start),
    .ext_en   (ext_en),
    .ext_trig (ext_trig),
    .mode     (mode),
    .tsel     (tsel),
    .busy     (busy),
    .done     (done)
  );

  adc_seq_eval #(.SMP_W(SMP_W), .DATA_W(DATA_W)) u_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .mode      (mode),
    .above_sel (above_sel),
    .sample    (sample_in),
    .thresh    (thresh),
    .result    (result),
    .end_set   (end_set)
  );

endmodule

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rmw = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [9:0] sample_in = 10'd0;
  logic       ext_trig = 1'b0;
  logic       busy;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cur_len = 0;
  int last_len = 0;
  int conv_len [4] = '{33, 48, 66, 90};
  int sens_len [4] = '{18, 33, 51, 75};

  always #2.5 clk = ~clk;

  adc_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rmw(bus_rmw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sample_in(sample_in), .ext_trig(ext_trig), .busy(busy), .irq(irq)
  );

  // busy run-length monitor at the port
  always @(negedge clk) begin
    if (busy) cur_len = cur_len + 1;
    else if (cur_len != 0) begin
      last_len = cur_len;
      cur_len = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wait_op(output int len);
    int guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    #0.5;
    len = last_len;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] hi0, lo0;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(3'd0, d); chk(d == 8'h00, "R3 reset ctrl", d, 0);
    rd(3'd1, d); chk(d == 8'h01, "R10 reset cfg", d, 1);
    rd(3'd2, d); chk(d == 8'h00, "R10 reset res_hi", d, 0);
    rd(3'd4, d); chk(d == 8'h00, "R10 reset thr", d, 0);
    chk(busy == 1'b0, "R3 reset busy", busy, 0);
    chk(irq == 1'b0, "R9 reset irq", irq, 0);

    // R10 cfg layout
    wr(3'd1, 8'hFF); rd(3'd1, d); chk(d == 8'h7F, "R10 cfg bits", d, 8'h7F);
    wr(3'd1, 8'h00); rd(3'd1, d); chk(d == 8'h00, "R10 cfg clear", d, 0);

    // R6 writing 0 to start does nothing
    wr(3'd0, 8'h00); @(negedge clk);
    chk(busy == 1'b0, "R6 start=0 no launch", busy, 0);

    // R1 / R2 length sweep, with R3 status bit
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 4; t++) begin
        wr(3'd1, 8'((t << 5) | (m << 2)));
        wr(3'd0, 8'h01);
        rd(3'd0, d);
        chk(d[2] == 1'b1 && busy, "R3 busy bit while running", d[2], 1);
        chk(d[0] == 1'b0, "R6 start reads 0", d[0], 0);
        wait_op(len);
        if (m == 0) chk(len == conv_len[t], "R1 convert length", len, conv_len[t]);
        else        chk(len == sens_len[t], "R2 sense length", len, sens_len[t]);
        rd(3'd0, d);
        chk(d[2] == 1'b0 && !busy, "R3 busy clear after end", d[2], 0);
      end
    end

    // R4 convert result sweep
    wr(3'd1, 8'h00);
    for (int s = 0; s < 1024; s += 93) begin
      sample_in = 10'(s);
      wr(3'd0, 8'h00);
      wr(3'd0, 8'h01);
      wait_op(len);
      rd(3'd2, d); chk(d == 8'(s >> 8), "R4 result high", d, s >> 8);
      rd(3'd3, d); chk(d == 8'(s & 255), "R4 result low", d, s & 255);
      rd(3'd0, d); chk(d[3] == 1'b1, "R4 end flag set", d[3], 1);
    end
    sample_in = 10'h3FF;
    wr(3'd0, 8'h01); wait_op(len);
    rd(3'd2, hi0); rd(3'd3, lo0);
    chk(hi0 == 8'h03 && lo0 == 8'hFF, "R4 full-scale result", {hi0, lo0}, 16'h03FF);

    // R5 sense compare sweep, threshold 0x80
    wr(3'd4, 8'h80);
    wr(3'd1, 8'h04);
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 7; k++) begin
        int top;
        bit exp_hit;
        case (k)
          0: top = 8'h00; 1: top = 8'h7E; 2: top = 8'h7F; 3: top = 8'h80;
          4: top = 8'h81; 5: top = 8'hC3; default: top = 8'hFF;
        endcase
        exp_hit = (c == 1) ? (top > 8'h80) : (top < 8'h80);
        wr(3'd0, 8'(c << 1));
        sample_in = 10'((top << 2) | (k & 3));
        wr(3'd0, 8'((c << 1) | 1));
        wait_op(len);
        rd(3'd0, d); chk(d[3] == exp_hit, "R5 sense flag", d[3], exp_hit);
        chk(d[1] == c[0], "R5 cond bit readback", d[1], c);
        rd(3'd2, d); chk(d == hi0, "R5 result high kept", d, hi0);
        rd(3'd3, d); chk(d == lo0, "R5 result low kept", d, lo0);
      end
    end

    // R7 external trigger
    sample_in = 10'd0;
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h01); @(negedge clk);
    chk(busy == 1'b0, "R7 sw start ignored", busy, 0);
    ext_trig = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R7 trigger edge launches", busy, 1);
    wait_op(len);
    chk(len == 33, "R7 triggered length", len, 33);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R7 held trigger launches once", busy, 0);
    ext_trig = 1'b0;

    // R8 start and tsel change while busy
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h60);
    wait_op(len);
    chk(len == 33, "R8 busy restart ignored", len, 33);
    wr(3'd1, 8'h00);

    // R9 sticky flag and irq
    wr(3'd0, 8'h08); rd(3'd0, d);
    chk(d[3] == 1'b1, "R9 write 1 keeps flag", d[3], 1);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    wr(3'd1, 8'h08); @(negedge clk);
    chk(irq == 1'b1, "R9 irq enabled", irq, 1);
    wr(3'd0, 8'h00); rd(3'd0, d);
    chk(d[3] == 1'b0, "R9 write 0 clears flag", d[3], 0);
    chk(irq == 1'b0, "R9 irq follows clear", irq, 0);
    wr(3'd0, 8'h01); wait_op(len);
    chk(irq == 1'b1, "R9 irq after conversion", irq, 1);
    wr(3'd0, 8'h00);

    // R11 rmw read
    bus_rmw = 1'b1; rd(3'd0, d);
    chk(d[3] == 1'b1, "R11 rmw read end bit", d[3], 1);
    bus_rmw = 1'b0; rd(3'd0, d);
    chk(d[3] == 1'b0, "R11 plain read end bit", d[3], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

endmodule